// File: doc/BRIEF.md
# Token-Passing Readout Controller

This block sequences the readout of one front-end chip on a data bus that several chips share. The chips form a chain. A single token travels along that chain, and a chip may drive the bus only while it holds the token. A readout cycle opens with a start pulse. The chip then waits for two things: its conversion must be complete, and the token must have arrived from the upstream chip. A token that turns up early is held until conversion finishes.

Once the chip has both, it reads its stored events from local memory and sends them on the bus, one word per clock. Each event occupies a fixed number of words. When the last word is out, the chip sends the token to the downstream chip as a one-clock pulse and falls into an idle low-power state. If the chip recorded no events, it leaves the bus alone and forwards the token one clock after receiving it.

The local memory is read asynchronously. Event `e`, word `w` sits at address `e*WORDS_PER_EVENT + w`.

Top module: `tokrd_top`

## Requirements
- R1: After reset, `idle` is 1 and `tokenOut`, `busEn` and `busValid` are 0. `busData` is 0 whenever `busEn` is 0.
- R2: In the cycle after `startReadout` is sampled high, `idle` is 0 and the bus is not driven. This holds in any state, and an active transfer is aborted.
- R3: Let N be the stored event count, with N greater than 0. If the token is sampled while `convDone` is high, `busEn` and `busValid` are both 1 from the next cycle for exactly N*WORDS_PER_EVENT consecutive cycles.
- R4: During a transfer, `memAddr` runs from 0 upward in steps of 1. `busData` equals the memory word at the current `memAddr`.
- R5: `tokenOut` is a pulse one cycle wide, in the cycle after the last word. `busEn` is 0 in that cycle.
- R6: With zero events, `busEn` stays 0 and `tokenOut` pulses in the cycle after the token is sampled.
- R7: A token sampled while `convDone` is low is remembered. The transfer, or the pass-on, starts in the cycle after `convDone` is first sampled high.
- R8: After `tokenOut`, the block is idle with `idle` at 1. Any further `tokenIn` is ignored until the next `startReadout`: no bus activity and no `tokenOut`.
- R9: An `eventCount` above MAX_EVENTS (5) is treated as MAX_EVENTS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReadout | input | 1 | Opens a readout cycle; returns the controller to waiting for the token |
| convDone | input | 1 | Level: A/D conversion finished |
| eventCount | input | CNT_W (3) | Number of stored events, sampled when the transfer begins |
| tokenIn | input | 1 | Token pulse from the upstream chip |
| tokenOut | output | 1 | Token pulse to the downstream chip |
| busEn | output | 1 | Output enable for the shared bus driver |
| busValid | output | 1 | Strobe marking a valid word on `busData` |
| busData | output | DATA_W (16) | Bus word; zero when not driving |
| memAddr | output | ADDR_W (5) | Read address to the local event memory |
| memData | input | DATA_W (16) | Read data, valid in the same cycle as `memAddr` |
| idle | output | 1 | High in the idle low-power state |

## Verification
The assertions take three things for granted about the inputs:
- `memData` follows `memAddr` within the same cycle.
- `eventCount` is stable from the token grant until the transfer ends.
- `tokenIn` does not arrive in the same cycle as `startReadout`.

The stimulus respects all three. It changes `eventCount` and `convDone` only around the start pulse. It raises tokens only after the start pulse has been sampled. It draws random event counts up to 7, so that saturation is exercised, together with random delays and random choices of early or late token. Directed runs add a reset check, a zero-event chain hop and an abort in mid-transfer.

// File: rtl/tokrd_pkg.sv
package tokrd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2,
    ST_PASS = 2'd3
  } rdState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearTok;
    logic armTok;
    logic load;
    logic advance;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic tokSeen;
    logic noEvents;
    logic lastWord;
  } dpStat_t;
endpackage

// File: rtl/tokrd_datapath.sv
module tokrd_datapath
  import tokrd_pkg::*;
#(
  parameter int DATA_W          = 16,
  parameter int MAX_EVENTS      = 5,
  parameter int WORDS_PER_EVENT = 4,
  parameter int CNT_W           = 3,
  parameter int ADDR_W          = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic              tokenIn,
  input  logic [CNT_W-1:0]  eventCount,
  input  logic [DATA_W-1:0] memData,
  output dpStat_t           stat,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] busData
);
  localparam int TOT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_EVENTS);

  logic              tokPend;
  logic [CNT_W-1:0]  evClamp;
  logic [TOT_W-1:0]  totalWords;
  logic [ADDR_W-1:0] wordCnt;

  // saturate the stored-event count at the memory depth
  always_comb begin
    evClamp = (eventCount > MAX_CNT) ? MAX_CNT : eventCount;
  end

  // token latch: remembers an early token until conversion completes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tokPend <= 1'b0;
    end else if (ctrl.clearTok) begin
      tokPend <= 1'b0;
    end else if (ctrl.armTok && tokenIn) begin
      tokPend <= 1'b1;
    end
  end

  // word counter and transfer length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordCnt    <= '0;
      totalWords <= '0;
    end else if (ctrl.load) begin
      wordCnt    <= '0;
      totalWords <= TOT_W'(evClamp) * TOT_W'(WORDS_PER_EVENT);
    end else if (ctrl.advance) begin
      wordCnt    <= wordCnt + 1'b1;
    end
  end

  always_comb begin
    stat.tokSeen  = tokPend || (ctrl.armTok && tokenIn);
    stat.noEvents = (evClamp == '0);
    stat.lastWord = ({1'b0, wordCnt} == (totalWords - 1'b1));
    memAddr       = wordCnt;
    busData       = ctrl.advance ? memData : '0;
  end

  // R4: address never runs past the transfer length
  a_r4_addr_in_range: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.advance |-> ({1'b0, wordCnt} < totalWords));

  // R4: address steps by one while sending continues
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.advance && !ctrl.load && !stat.lastWord) |=> (wordCnt == $past(wordCnt) + 1'b1));

  // R9: loaded length never exceeds the memory depth
  a_r9_len_saturated: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> (totalWords <= TOT_W'(MAX_EVENTS * WORDS_PER_EVENT)));
endmodule

// File: rtl/tokrd_control.sv
module tokrd_control
  import tokrd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReadout,
  input  logic    convDone,
  input  dpStat_t stat,
  output dpCtrl_t ctrl,
  output logic    busEn,
  output logic    busValid,
  output logic    tokenOut,
  output logic    idle
);
  rdState_e state, stateNext;
  logic     grant;

  assign grant = (state == ST_WAIT) && stat.tokSeen && convDone && !startReadout;

  always_comb begin
    stateNext = state;
    if (startReadout) begin
      stateNext = ST_WAIT;
    end else begin
      unique case (state)
        ST_IDLE: stateNext = ST_IDLE;
        ST_WAIT: if (grant) stateNext = stat.noEvents ? ST_PASS : ST_SEND;
        ST_SEND: if (stat.lastWord) stateNext = ST_PASS;
        ST_PASS: stateNext = ST_IDLE;
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctrl.clearTok = startReadout || grant;
    ctrl.armTok   = (state == ST_WAIT);
    ctrl.load     = grant;
    ctrl.advance  = (state == ST_SEND);
    busEn         = (state == ST_SEND);
    busValid      = (state == ST_SEND);
    tokenOut      = (state == ST_PASS);
    idle          = (state == ST_IDLE);
  end

  // R5: bus released while the token is handed on
  a_r5_no_bus_on_pass: assert property (@(posedge clk) disable iff (!rstN)
    tokenOut |-> !busEn);

  // R5: token pulse is one cycle wide
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    tokenOut |=> !tokenOut);

  // R8: idle after the token has gone, unless a new cycle starts
  a_r8_idle_after_pass: assert property (@(posedge clk) disable iff (!rstN)
    (tokenOut && !startReadout) |=> idle);

  // R8: an idle chip stays idle without a start pulse
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (idle && !startReadout) |=> (idle && !busEn && !tokenOut));

  // R7: a transfer begins only once conversion was seen complete
  a_r7_send_after_conv: assert property (@(posedge clk) disable iff (!rstN)
    (busEn && !$past(busEn)) |-> $past(convDone));

  // R2: start pulse always lands in the waiting state
  a_r2_start_waits: assert property (@(posedge clk) disable iff (!rstN)
    startReadout |=> (!idle && !busEn && !tokenOut));
endmodule

// File: rtl/tokrd_top.sv
module tokrd_top
  import tokrd_pkg::*;
#(
  parameter int  DATA_W          = 16,
  parameter int  MAX_EVENTS      = 5,
  parameter int  WORDS_PER_EVENT = 4,
  localparam int CNT_W           = $clog2(MAX_EVENTS + 1),
  localparam int ADDR_W          = $clog2(MAX_EVENTS * WORDS_PER_EVENT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReadout,
  input  logic              convDone,
  input  logic [CNT_W-1:0]  eventCount,
  input  logic              tokenIn,
  output logic              tokenOut,
  output logic              busEn,
  output logic              busValid,
  output logic [DATA_W-1:0] busData,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  output logic              idle
);
  dpCtrl_t ctrl;
  dpStat_t stat;

  tokrd_control control_i (
    .clk          (clk),
    .rstN         (rstN),
    .startReadout (startReadout),
    .convDone     (convDone),
    .stat         (stat),
    .ctrl         (ctrl),
    .busEn        (busEn),
    .busValid     (busValid),
    .tokenOut     (tokenOut),
    .idle         (idle)
  );

  tokrd_datapath #(
    .DATA_W          (DATA_W),
    .MAX_EVENTS      (MAX_EVENTS),
    .WORDS_PER_EVENT (WORDS_PER_EVENT),
    .CNT_W           (CNT_W),
    .ADDR_W          (ADDR_W)
  ) datapath_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .tokenIn    (tokenIn),
    .eventCount (eventCount),
    .memData    (memData),
    .stat       (stat),
    .memAddr    (memAddr),
    .busData    (busData)
  );

  // R1: bus data is quiet whenever the driver is off
  a_r1_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    !busEn |-> (busData == '0 && !busValid));
endmodule

// File: tb/tokrd_top_tb_top.sv
`timescale 1ns/1ps
module tokrd_top_tb_top;
  localparam int DATA_W = 16;
  localparam int MAXEV  = 5;
  localparam int WPE    = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReadout = 1'b0;
  logic        convDone = 1'b0;
  logic [2:0]  eventCount = '0;
  logic        tokenIn = 1'b0;
  logic        tokenOut, busEn, busValid, idle;
  logic [15:0] busData, memData;
  logic [4:0]  memAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [15:0] memWord(input int a);
    return 16'((a * 16'h0B3D) ^ 16'h5AC3);
  endfunction

  assign memData = memWord(int'(memAddr));

  tokrd_top dut_i (
    .clk(clk), .rstN(rstN), .startReadout(startReadout), .convDone(convDone),
    .eventCount(eventCount), .tokenIn(tokenIn), .tokenOut(tokenOut),
    .busEn(busEn), .busValid(busValid), .busData(busData),
    .memAddr(memAddr), .memData(memData), .idle(idle)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkQuiet(input string req);
    chk(busEn == 1'b0, {req, " busEn"}, busEn, 0);
    chk(tokenOut == 1'b0, {req, " tokenOut"}, tokenOut, 0);
  endtask

  // drives a whole readout cycle and checks it word by word
  task automatic readout(input int n, input bit early, input int hold);
    int eff;
    eff = (n > MAXEV) ? MAXEV : n;   // R9 saturation
    @(negedge clk);
    eventCount = 3'(n); convDone = !early; startReadout = 1'b1;
    @(negedge clk);
    startReadout = 1'b0;
    chk(idle == 1'b0, "R2 idle after start", idle, 0);
    checkQuiet("R2");
    if (early) begin
      tokenIn = 1'b1;
      @(negedge clk);
      tokenIn = 1'b0;
      for (int h = 0; h <= hold; h++) begin
        checkQuiet("R7 token held");
        @(negedge clk);
      end
      convDone = 1'b1;
      @(negedge clk);
    end else begin
      for (int h = 0; h < hold; h++) begin
        checkQuiet("R3 waiting");
        @(negedge clk);
      end
      tokenIn = 1'b1;
      @(negedge clk);
      tokenIn = 1'b0;
    end
    for (int k = 0; k < eff * WPE; k++) begin
      chk(busEn && busValid, "R3 driving", busEn, 1);
      chk(int'(memAddr) == k, "R4 address", int'(memAddr), k);
      chk(busData == memWord(k), "R4 data", int'(busData), int'(memWord(k)));
      chk(tokenOut == 1'b0, "R5 no early token", tokenOut, 0);
      @(negedge clk);
    end
    chk(tokenOut == 1'b1, (eff == 0) ? "R6 token passed" : "R5 token after last", tokenOut, 1);
    chk(busEn == 1'b0, (eff == 0) ? "R6 bus unused" : "R5 bus released", busEn, 0);
    @(negedge clk);
    chk(tokenOut == 1'b0, "R5 pulse width", tokenOut, 0);
    chk(idle == 1'b1, "R8 idle", idle, 1);
    convDone = 1'b0;
    tokenIn = 1'b1;
    @(negedge clk);
    tokenIn = 1'b0;
    checkQuiet("R8 token ignored");
    @(negedge clk);
    checkQuiet("R8 token ignored");
    chk(idle == 1'b1, "R8 still idle", idle, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    chk(idle == 1'b1, "R1 reset idle", idle, 1);
    chk(busValid == 1'b0 && busData == '0, "R1 reset bus", int'(busData), 0);
    checkQuiet("R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    tokenIn = 1'b1;              // R8: token before any start is ignored
    @(negedge clk);
    tokenIn = 1'b0;
    checkQuiet("R8 pre-start token");
    chk(idle == 1'b1, "R8 pre-start idle", idle, 1);

    readout(0, 1'b0, 0);         // R6 zero events
    readout(0, 1'b1, 2);         // R6 with early token, R7
    readout(1, 1'b0, 0);
    readout(5, 1'b0, 1);         // full depth
    readout(7, 1'b0, 0);         // R9 saturates
    readout(3, 1'b1, 3);         // R7 early token

    // R2 abort mid-transfer, then a clean restart
    @(negedge clk);
    eventCount = 3'd4; convDone = 1'b1; startReadout = 1'b1;
    @(negedge clk);
    startReadout = 1'b0; tokenIn = 1'b1;
    @(negedge clk);
    tokenIn = 1'b0;
    repeat (3) @(negedge clk);
    chk(busEn == 1'b1, "R3 mid-transfer", busEn, 1);
    startReadout = 1'b1;
    @(negedge clk);
    startReadout = 1'b0;
    chk(busEn == 1'b0, "R2 abort", busEn, 0);
    chk(idle == 1'b0, "R2 abort waits", idle, 0);
    chk(tokenOut == 1'b0, "R2 abort no token", tokenOut, 0);
    convDone = 1'b0;
    readout(2, 1'b0, 0);

    for (int i = 0; i < 25; i++) begin
      readout(int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), int'($urandom_range(0, 4)));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule